// File: doc/BRIEF.md
# Glitch-Free Clock Group Stop Gate

This block turns a group of clock outputs on and off in answer to an active-low stop request that may arrive at any time, unrelated to the source clock. The request is first passed through a synchronizer in the source clock domain. Each gated output can only stop after it has finished a high phase, so it always rests at 0. It restarts on a rising edge, so its first high phase has full width. Every gated output also has a static enable bit from a configuration register. When that bit is 0, the output stays low whatever the stop request does.

Once the group has restarted, it keeps running for a minimum number of its own cycles, even if a new stop request arrives sooner. A stop that comes during that window is held pending and takes effect when the window ends. One extra output runs free of the stop request: it follows only its own enable bit. The gating enables are registered on the falling edge of the source clock, so they can only change while the clock is low.

Top module: `clk_stop_gate`

## Requirements
- R1: With default parameters and the group running, the gated outputs give exactly 3 more high pulses after the stop request goes low, counting rising edges of the source clock. From the 4th rising edge onward they stay low.
- R2: While stopped, every gated output reads 0 in both phases of the source clock. The free-running output keeps toggling during that time.
- R3: After the stop request goes high, the first high pulse on the gated outputs comes at the 4th rising edge of the source clock. It is a complete high phase.
- R4: No output is ever high while the source clock is low.
- R5: After a restart, the group gives at least MIN_RUN high pulses before it can stop again. With a stop request asserted right after the restart, it gives exactly MIN_RUN pulses (default 10) and then stops.
- R6: The free-running output ignores the stop request. It toggles with the source clock when its enable input is 1 and is held low when the enable is 0.
- R7: Gated output i (bit i of the output bus) toggles only if bit i of the enable bus is 1. It stays low when that bit is 0, whether or not a stop is requested.
- R8: While reset is low, all outputs are low. After reset the group runs at once with no minimum-run window pending, and the synchronizer comes out of reset in the "no stop" state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clkSrc | input | 1 | Source clock that is gated |
| rstN | input | 1 | Asynchronous active-low reset |
| stopReqN | input | 1 | Asynchronous active-low stop request for the gated group |
| outEnable | input | NUM_OUT | Static enable for each gated output (1 = allowed to run) |
| freeEnable | input | 1 | Static enable for the free-running output |
| clkOut | output | NUM_OUT | Gated clock group |
| clkFree | output | 1 | Free-running clock output, unaffected by the stop request |

## Verification
The checker relates the enable bits to the gating state sampled at the next rising edge. This assumes that the configuration enables change only during the high phase of the source clock and never at an edge. It also assumes that reset, once released, stays high for at least a cycle. The latency properties compare against the stop request sampled on rising edges, so any change between edges is simply seen one edge later. The stimulus changes every input one nanosecond after a rising edge, well before the falling edge. It holds the stop request high during reset and for the cycles just after it, which keeps every sampled history defined.

// File: rtl/clkstop_pkg.sv
`timescale 1ns/1ps
package clkstop_pkg;
  // Strobes handed from the control to the gating datapath
  typedef struct packed {
    logic runGate;   // group allowed to run this cycle
    logic freeGate;  // free-running member allowed to run
  } gateStrobe_t;
endpackage

// File: rtl/clkstop_ctrl.sv
`timescale 1ns/1ps
module clkstop_ctrl
  import clkstop_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int MIN_RUN     = 10
) (
  input  logic        clkSrc,
  input  logic        rstN,
  input  logic        stopReqN,
  input  logic        freeEnable,
  output gateStrobe_t strobe
);
  localparam int CW = $clog2(MIN_RUN + 1);
  localparam logic [CW-1:0] RUN_LAST = CW'(MIN_RUN - 1);

  // Request synchronizer, resets to "no stop"
  logic [SYNC_STAGES-1:0] syncQ;
  always_ff @(posedge clkSrc or negedge rstN) begin
    if (!rstN) syncQ <= '1;
    else       syncQ <= {syncQ[SYNC_STAGES-2:0], stopReqN};
  end

  logic stopSeen;
  assign stopSeen = ~syncQ[SYNC_STAGES-1];

  // Run state with minimum-run counter
  logic          runEn;
  logic [CW-1:0] runCnt;
  logic          runDone;
  assign runDone = (runCnt >= RUN_LAST);

  always_ff @(posedge clkSrc or negedge rstN) begin
    if (!rstN) begin
      runEn  <= 1'b1;
      runCnt <= RUN_LAST;
    end else if (runEn) begin
      if (stopSeen && runDone) runEn <= 1'b0;
      else if (!runDone)       runCnt <= runCnt + CW'(1);
    end else if (!stopSeen) begin
      runEn  <= 1'b1;
      runCnt <= '0;
    end
  end

  assign strobe.runGate  = runEn;
  assign strobe.freeGate = freeEnable;
endmodule

// File: rtl/clkstop_gate.sv
`timescale 1ns/1ps
module clkstop_gate
  import clkstop_pkg::*;
#(
  parameter int NUM_OUT = 4
) (
  input  logic               clkSrc,
  input  logic               rstN,
  input  gateStrobe_t        strobe,
  input  logic [NUM_OUT-1:0] outEnable,
  output logic [NUM_OUT-1:0] clkOut,
  output logic               clkFree,
  output logic [NUM_OUT-1:0] gateState,
  output logic               freeState
);
  // Enables captured on the falling edge: they change only while clkSrc is low
  for (genvar g = 0; g < NUM_OUT; g++) begin : g_lane
    logic laneQ;
    always_ff @(negedge clkSrc or negedge rstN) begin
      if (!rstN) laneQ <= 1'b0;
      else       laneQ <= strobe.runGate & outEnable[g];
    end
    assign clkOut[g]    = clkSrc & laneQ;
    assign gateState[g] = laneQ;
  end

  logic freeQ;
  always_ff @(negedge clkSrc or negedge rstN) begin
    if (!rstN) freeQ <= 1'b0;
    else       freeQ <= strobe.freeGate;
  end
  assign clkFree   = clkSrc & freeQ;
  assign freeState = freeQ;
endmodule

// File: rtl/clk_stop_gate.sv
`timescale 1ns/1ps
module clk_stop_gate
  import clkstop_pkg::*;
#(
  parameter int NUM_OUT     = 4,
  parameter int SYNC_STAGES = 2,
  parameter int MIN_RUN     = 10
) (
  input  logic               clkSrc,
  input  logic               rstN,
  input  logic               stopReqN,
  input  logic [NUM_OUT-1:0] outEnable,
  input  logic               freeEnable,
  output logic [NUM_OUT-1:0] clkOut,
  output logic               clkFree
);
  gateStrobe_t        strobe;
  logic [NUM_OUT-1:0] gateState;
  logic               freeState;

  clkstop_ctrl #(.SYNC_STAGES(SYNC_STAGES), .MIN_RUN(MIN_RUN)) u_ctrl (
    .clkSrc    (clkSrc),
    .rstN      (rstN),
    .stopReqN  (stopReqN),
    .freeEnable(freeEnable),
    .strobe    (strobe)
  );

  clkstop_gate #(.NUM_OUT(NUM_OUT)) u_gate (
    .clkSrc    (clkSrc),
    .rstN      (rstN),
    .strobe    (strobe),
    .outEnable (outEnable),
    .clkOut    (clkOut),
    .clkFree   (clkFree),
    .gateState (gateState),
    .freeState (freeState)
  );
endmodule

// File: rtl/clk_stop_gate_chk.sv
`timescale 1ns/1ps
module clk_stop_gate_chk #(
  parameter int NUM_OUT     = 4,
  parameter int SYNC_STAGES = 2,
  parameter int MIN_RUN     = 10
) (
  input logic               clkSrc,
  input logic               rstN,
  input logic               stopReqN,
  input logic [NUM_OUT-1:0] outEnable,
  input logic               freeEnable,
  input logic               runGate,
  input logic [NUM_OUT-1:0] gateState,
  input logic               freeState
);
  localparam int HW = $clog2(MIN_RUN + 1);

  // Cycles the group has been running since its last start
  logic [HW-1:0] hiCnt;
  always_ff @(posedge clkSrc or negedge rstN) begin
    if (!rstN)                 hiCnt <= HW'(MIN_RUN);
    else if (!runGate)         hiCnt <= '0;
    else if (hiCnt < HW'(MIN_RUN)) hiCnt <= hiCnt + HW'(1);
  end

  // R1: a stop only follows a request seen through the synchronizer
  a_r1_stop_after_sync: assert property (@(posedge clkSrc) disable iff (!rstN)
    $fell(runGate) |-> !$past(stopReqN, SYNC_STAGES + 1));

  // R3: a restart only follows a released request seen through the synchronizer
  a_r3_start_after_sync: assert property (@(posedge clkSrc) disable iff (!rstN)
    $rose(runGate) |-> $past(stopReqN, SYNC_STAGES + 1));

  // R5: the group never stops before its minimum run has elapsed
  a_r5_min_run: assert property (@(posedge clkSrc) disable iff (!rstN)
    $fell(runGate) |-> (hiCnt >= HW'(MIN_RUN)));

  // R2: no gated lane is open while the group is stopped
  a_r2_gate_needs_run: assert property (@(posedge clkSrc) disable iff (!rstN)
    $past(rstN) && (gateState != '0) |-> runGate);

  // R7: a lane whose enable bit is 0 is never open
  a_r7_enable_mask: assert property (@(posedge clkSrc) disable iff (!rstN)
    $past(rstN) |-> ((gateState & ~outEnable) == '0));

  // R6: the free lane follows only its enable
  a_r6_free_follows: assert property (@(posedge clkSrc) disable iff (!rstN)
    $past(rstN) |-> (freeState == freeEnable));
endmodule

bind clk_stop_gate clk_stop_gate_chk #(
  .NUM_OUT(NUM_OUT), .SYNC_STAGES(SYNC_STAGES), .MIN_RUN(MIN_RUN)
) u_chk (
  .clkSrc    (clkSrc),
  .rstN      (rstN),
  .stopReqN  (stopReqN),
  .outEnable (outEnable),
  .freeEnable(freeEnable),
  .runGate   (strobe.runGate),
  .gateState (gateState),
  .freeState (freeState)
);

// File: tb/sim_clk_stop_gate.sv
`timescale 1ns/1ps
module sim_clk_stop_gate;
  localparam int NUM_OUT = 4;
  localparam int MIN_RUN = 10;

  logic               clkSrc = 1'b0;
  logic               rstN = 1'b0;
  logic               stopReqN = 1'b1;
  logic [NUM_OUT-1:0] outEnable = '1;
  logic               freeEnable = 1'b1;
  logic [NUM_OUT-1:0] clkOut;
  logic               clkFree;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [NUM_OUT-1:0] hiOut;
  logic               hiFree;

  always #2.5 clkSrc = ~clkSrc;

  clk_stop_gate #(.NUM_OUT(NUM_OUT), .SYNC_STAGES(2), .MIN_RUN(MIN_RUN)) u0 (
    .clkSrc(clkSrc), .rstN(rstN), .stopReqN(stopReqN), .outEnable(outEnable),
    .freeEnable(freeEnable), .clkOut(clkOut), .clkFree(clkFree)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Wait for a rising edge and sample the high phase
  task automatic tick();
    @(posedge clkSrc);
    #1;
    hiOut  = clkOut;
    hiFree = clkFree;
  endtask

  // R4: every output is low during the low phase
  always @(negedge clkSrc) begin
    #1;
    if (rstN === 1'b1 && !finished) begin
      checks++;
      if (clkOut !== '0 || clkFree !== 1'b0) begin
        errors++;
        $display("FAIL R4 actual=%0h expected=0 at %0t", {clkFree, clkOut}, $time);
      end
    end
  end

  // {stopReqN, outEnable[3:0], freeEnable, expOut[3:0], expFree}
  localparam logic [10:0] VEC [6] = '{
    {1'b1, 4'b1111, 1'b1, 4'b1111, 1'b1},
    {1'b1, 4'b1010, 1'b0, 4'b1010, 1'b0},
    {1'b0, 4'b1111, 1'b1, 4'b0000, 1'b1},
    {1'b0, 4'b0101, 1'b0, 4'b0000, 1'b0},
    {1'b1, 4'b0110, 1'b1, 4'b0110, 1'b1},
    {1'b0, 4'b1100, 1'b1, 4'b0000, 1'b1}
  };

  task automatic finish_run();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int n;
    // R8: reset holds all outputs low
    repeat (3) tick();
    check("R8 reset out", 32'(hiOut), 32'h0);
    check("R8 reset free", 32'(hiFree), 32'h0);
    rstN = 1'b1;
    tick();
    check("R8 runs right after reset", 32'(hiOut), 32'hF);
    // R8: no minimum window after reset, so a stop acts with base latency
    stopReqN = 1'b0;
    n = 0;
    for (int i = 0; i < 40; i++) begin tick(); if (hiOut[0] === 1'b0) break; n++; end
    check("R8 stop latency after reset", 32'(n), 32'd3);
    stopReqN = 1'b1;
    repeat (20) tick();

    // Table of steady-state vectors (R2, R6, R7)
    foreach (VEC[k]) begin
      stopReqN   = VEC[k][10];
      outEnable  = VEC[k][9:6];
      freeEnable = VEC[k][5];
      repeat (20) tick();
      check(VEC[k][10] ? "R7 lanes" : "R2 stopped lanes", 32'(hiOut), 32'(VEC[k][4:1]));
      check("R6 free lane", 32'(hiFree), 32'(VEC[k][0]));
    end

    // R3: restart on the 4th rising edge
    outEnable = '1; freeEnable = 1'b1;
    tick();
    stopReqN = 1'b1;
    n = 0;
    for (int i = 0; i < 40; i++) begin tick(); n++; if (hiOut[0] === 1'b1) break; end
    check("R3 restart edge", 32'(n), 32'd4);
    #1.4;
    check("R3 full high phase", 32'(clkOut), 32'hF);
    repeat (20) tick();

    // R1: stop latency of 3 pulses
    stopReqN = 1'b0;
    n = 0;
    for (int i = 0; i < 40; i++) begin tick(); if (hiOut[0] === 1'b0) break; n++; end
    check("R1 pulses after stop", 32'(n), 32'd3);

    // R2: stays low while stopped, free lane keeps running
    for (int i = 0; i < 10; i++) begin
      tick();
      check("R2 held low", 32'(hiOut), 32'h0);
      check("R6 free during stop", 32'(hiFree), 32'h1);
    end

    // R5: stop right after restart still yields MIN_RUN pulses
    stopReqN = 1'b1;
    for (int i = 0; i < 40; i++) begin tick(); if (hiOut[0] === 1'b1) break; end
    stopReqN = 1'b0;
    n = 1;
    for (int i = 0; i < 40; i++) begin tick(); if (hiOut[0] === 1'b0) break; n++; end
    check("R5 minimum run pulses", 32'(n), 32'(MIN_RUN));
    repeat (5) tick();
    check("R5 stopped after window", 32'(hiOut), 32'h0);

    finish_run();
  end
endmodule